// File: doc/BRIEF.md
# Tick-Driven Down-Counting Event Timer

This block is a single event timer for a system tick. It counts down by one on each cycle where an external tick enable is high, and a 1 MHz tick is the expected source. Software arms it with one 32-bit write. That word holds three things: a run flag, an auto-reload flag and a count field loaded with the wanted interval minus one. Loading N−1 therefore makes the timer expire on the N-th tick. Loading zero gives the shortest interval, which is a single tick.

On expiry the timer raises a level-high interrupt and holds it until software acknowledges it. Software acknowledges by writing a one to bit 30 of a separate status word. With auto-reload set, the timer reloads the stored interval and keeps going. Without it, the timer clears its own run flag and stops. A write of zero to the control word halts the timer. Any control write restarts the count from the new value at once.

Top module: `tick_downtimer`

## Requirements
- R1: After reset, irq is 0 and both the control word (offset 0x0) and the status word (offset 0x4) read as 0.
- R2: Writing the control word with bit 31 = 1, bit 30 = 0 and bits [28:0] = N−1 keeps irq low through N−1 ticks and makes it go high after the N-th tick edge.
- R3: On a one-shot expiry, control bit 31 reads back 0 and the count stays at 0. After an acknowledge, further ticks raise no new interrupt.
- R4: With control bit 30 = 1, each expiry reloads the count from bits [28:0] and leaves bit 31 set, so the interrupt repeats every N ticks.
- R5: A count field of 0 expires on the first tick, in both periodic and one-shot mode.
- R6: Writing 0 to the control word stops the timer. The control and status words read 0 and ticks raise no interrupt.
- R7: Any control write replaces the count with the written bits [28:0] on the next cycle, whatever count was running before.
- R8: A status write with bit 30 = 1 clears the pending interrupt. A status write with bit 30 = 0 leaves it unchanged, whatever the other bits hold.
- R9: When an expiry and an acknowledge fall in the same cycle, the interrupt stays pending.
- R10: The count changes only on cycles where tick is high. Idle cycles hold it.
- R11: When a control write and a tick fall in the same cycle, the write wins. The count takes the written value and that tick is not counted.
- R12: The status word reads the pending flag on bit 30 and the count on bits [28:0]. The control word reads bit 31 run, bit 30 periodic and bits [28:0] reload. All other bits read 0. Reads with bus_sel low, or at any other offset, return 0.
- R13: The count field holds values up to 0x1FFFFFFF. Write bit 29 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, one cycle per timer tick |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 3 | Byte offset: 0x0 control, 0x4 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from addr) |
| irq | output | 1 | Level-high pending interrupt |

## Verification
Two pairs of events can land in the same cycle. The first is an expiry with an acknowledge. The bench runs a periodic timer with a zero interval so that every tick expires, then raises the tick and a status write carrying bit 30 in one cycle. It expects irq still high afterwards, and a lone acknowledge on the next cycle must then drop it. The second pair is a tick with a control write. The bench writes a new interval while a periodic count is running and checks that the status count reads the written value, not the decremented one.

// File: rtl/dtmr_pkg.sv
`timescale 1ns/1ps
package dtmr_pkg;
    localparam int unsigned DTMR_DATA_W   = 32;
    localparam int unsigned DTMR_CNT_W    = 29;
    localparam int unsigned DTMR_ADDR_W   = 3;
    localparam int unsigned DTMR_RUN_BIT  = 31;
    localparam int unsigned DTMR_AUTO_BIT = 30;
    localparam int unsigned DTMR_ACK_BIT  = 30;
    localparam int unsigned DTMR_PAD_W    = DTMR_DATA_W - DTMR_CNT_W - 2;
    localparam logic [DTMR_ADDR_W-1:0] DTMR_OFS_CFG  = 3'h0;
    localparam logic [DTMR_ADDR_W-1:0] DTMR_OFS_STAT = 3'h4;

    typedef logic [DTMR_CNT_W-1:0]  dtmr_cnt_t;
    typedef logic [DTMR_DATA_W-1:0] dtmr_word_t;

    typedef struct packed {
        logic      run;
        logic      auto_rl;
        dtmr_cnt_t reload;
    } dtmr_cfg_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CFG  = 2'd1,
        SEL_STAT = 2'd2
    } dtmr_sel_e;

    function automatic dtmr_sel_e dtmr_decode(input logic [DTMR_ADDR_W-1:0] a);
        case (a)
            DTMR_OFS_CFG:  return SEL_CFG;
            DTMR_OFS_STAT: return SEL_STAT;
            default:       return SEL_NONE;
        endcase
    endfunction

    function automatic dtmr_cfg_t dtmr_unpack(input dtmr_word_t w);
        dtmr_cfg_t c;
        c.run     = w[DTMR_RUN_BIT];
        c.auto_rl = w[DTMR_AUTO_BIT];
        c.reload  = w[DTMR_CNT_W-1:0];
        return c;
    endfunction

    function automatic dtmr_word_t dtmr_pack_cfg(input dtmr_cfg_t c);
        return {c.run, c.auto_rl, {DTMR_PAD_W{1'b0}}, c.reload};
    endfunction

    function automatic dtmr_word_t dtmr_pack_stat(input logic pend, input dtmr_cnt_t cnt);
        return {1'b0, pend, {DTMR_PAD_W{1'b0}}, cnt};
    endfunction
endpackage

// File: rtl/dtmr_regs.sv
`timescale 1ns/1ps
module dtmr_regs
    import dtmr_pkg::*;
(
    input  logic                   bus_sel,
    input  logic                   bus_wr,
    input  logic [DTMR_ADDR_W-1:0] bus_addr,
    input  dtmr_word_t             bus_wdata,
    input  dtmr_cfg_t              cfg_q,
    input  dtmr_cnt_t              count_q,
    input  logic                   pend,
    output logic                   cfg_load,
    output dtmr_cfg_t              cfg_new,
    output logic                   ack,
    output dtmr_word_t             bus_rdata
);
    dtmr_sel_e sel;
    logic      unused_wbits;

    assign sel          = dtmr_decode(bus_addr);
    assign cfg_load     = bus_sel && bus_wr && (sel == SEL_CFG);
    assign ack          = bus_sel && bus_wr && (sel == SEL_STAT) && bus_wdata[DTMR_ACK_BIT];
    assign cfg_new      = dtmr_unpack(bus_wdata);
    assign unused_wbits = ^bus_wdata[DTMR_DATA_W-3:DTMR_CNT_W];

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (sel)
                SEL_CFG:  bus_rdata = dtmr_pack_cfg(cfg_q);
                SEL_STAT: bus_rdata = dtmr_pack_stat(pend, count_q);
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dtmr_counter.sv
`timescale 1ns/1ps
module dtmr_counter
    import dtmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      load,
    input  dtmr_cfg_t cfg_in,
    output dtmr_cfg_t cfg_q,
    output dtmr_cnt_t count_q,
    output logic      expire
);
    logic at_zero;
    logic step;

    assign at_zero = (count_q == '0);
    assign step    = tick && cfg_q.run && !load;
    assign expire  = step && at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            count_q <= '0;
        end else if (load) begin
            cfg_q   <= cfg_in;
            count_q <= cfg_in.reload;
        end else if (step) begin
            if (at_zero) begin
                if (cfg_q.auto_rl) count_q   <= cfg_q.reload;
                else               cfg_q.run <= 1'b0;
            end else begin
                count_q <= count_q - dtmr_cnt_t'(1);
            end
        end
    end

    // R10: no tick and no write keeps the count
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(count_q));
    // R2: a running nonzero count steps down by one per tick
    p_dec_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && cfg_q.run && count_q != '0) |=> (count_q == $past(count_q) - dtmr_cnt_t'(1)));
    // R7 / R11: a control write restarts from the written value
    p_restart_r7: assert property (@(posedge clk) disable iff (rst)
        load |=> (count_q == $past(cfg_in.reload)));
    // R3: one-shot expiry drops the run flag
    p_oneshot_r3: assert property (@(posedge clk) disable iff (rst)
        (expire && !cfg_q.auto_rl) |=> !cfg_q.run);
    // R4: periodic expiry reloads and keeps running
    p_periodic_r4: assert property (@(posedge clk) disable iff (rst)
        (expire && cfg_q.auto_rl) |=> (cfg_q.run && count_q == $past(cfg_q.reload)));
endmodule

// File: rtl/dtmr_irq.sv
`timescale 1ns/1ps
module dtmr_irq (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic ack,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst)         pend <= 1'b0;
        else if (expire) pend <= 1'b1;
        else if (ack)    pend <= 1'b0;
    end

    // R9: an expiry sets the flag even with an acknowledge in the same cycle
    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        expire |=> pend);
    // R8: a lone acknowledge clears the flag
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (ack && !expire) |=> !pend);
endmodule

// File: rtl/tick_downtimer.sv
`timescale 1ns/1ps
module tick_downtimer
    import dtmr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick,
    input  logic                   bus_sel,
    input  logic                   bus_wr,
    input  logic [DTMR_ADDR_W-1:0] bus_addr,
    input  logic [DTMR_DATA_W-1:0] bus_wdata,
    output logic [DTMR_DATA_W-1:0] bus_rdata,
    output logic                   irq
);
    dtmr_cfg_t cfg_q;
    dtmr_cfg_t cfg_new;
    dtmr_cnt_t count_q;
    logic      cfg_load;
    logic      ack;
    logic      expire;
    logic      pend;

    dtmr_regs u_regs (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cfg_q     (cfg_q),
        .count_q   (count_q),
        .pend      (pend),
        .cfg_load  (cfg_load),
        .cfg_new   (cfg_new),
        .ack       (ack),
        .bus_rdata (bus_rdata)
    );

    dtmr_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .load    (cfg_load),
        .cfg_in  (cfg_new),
        .cfg_q   (cfg_q),
        .count_q (count_q),
        .expire  (expire)
    );

    dtmr_irq u_irq (
        .clk    (clk),
        .rst    (rst),
        .expire (expire),
        .ack    (ack),
        .pend   (pend)
    );

    assign irq = pend;

    // R6: a stopped timer never raises a new interrupt
    p_stopped_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.run && !cfg_load && !irq) |=> !irq);
endmodule

// File: tb/sim_tick_downtimer.sv
`timescale 1ns/1ps
module sim_tick_downtimer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          n_checks = 0;
    int          n_errors = 0;

    localparam logic [2:0] A_CFG  = 3'h0;
    localparam logic [2:0] A_STAT = 3'h4;
    localparam logic [31:0] ACK   = 32'h4000_0000;

    tick_downtimer u0 (
        .clk(clk), .rst(rst), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one cycle, starting and ending at a falling edge
    task automatic step(input logic t, input logic w, input logic [2:0] a, input logic [31:0] d);
        tick = t; bus_sel = w; bus_wr = w; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        tick = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        step(1'b0, 1'b1, a, d);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, A_CFG, '0);
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq", {31'b0, irq}, 32'h0);
        rd(A_CFG, d);  check("R1 ctrl", d, 32'h0);
        rd(A_STAT, d); check("R1 stat", d, 32'h0);
    endtask

    task automatic t_oneshot();
        logic [31:0] d;
        wr(A_CFG, 32'h8000_0004);
        ticks(4);
        check("R2 no early irq", {31'b0, irq}, 32'h0);
        rd(A_STAT, d); check("R2 count after 4", d, 32'h0);
        ticks(1);
        check("R2 irq after 5", {31'b0, irq}, 32'h1);
        rd(A_CFG, d);  check("R3 run cleared", d, 32'h0000_0004);
        rd(A_STAT, d); check("R3 stat pend", d, 32'h4000_0000);
        wr(A_STAT, ACK);
        ticks(6);
        check("R3 no re-fire", {31'b0, irq}, 32'h0);
        rd(A_STAT, d); check("R3 count held", d, 32'h0);
    endtask

    task automatic t_periodic();
        logic [31:0] d;
        wr(A_CFG, 32'hC000_0002);
        ticks(3);
        check("R4 first expiry", {31'b0, irq}, 32'h1);
        rd(A_STAT, d); check("R4 reloaded", d, 32'h4000_0002);
        rd(A_CFG, d);  check("R4 run kept", d, 32'hC000_0002);
        wr(A_STAT, ACK);
        ticks(2);
        check("R4 quiet mid-period", {31'b0, irq}, 32'h0);
        ticks(1);
        check("R4 second expiry", {31'b0, irq}, 32'h1);
        wr(A_STAT, ACK);
    endtask

    task automatic t_minimum();
        wr(A_CFG, 32'hC000_0000);
        ticks(1);
        check("R5 periodic 1 tick", {31'b0, irq}, 32'h1);
        wr(A_STAT, ACK);
        ticks(1);
        check("R5 periodic again", {31'b0, irq}, 32'h1);
        wr(A_CFG, 32'h8000_0000);
        wr(A_STAT, ACK);
        ticks(1);
        check("R5 oneshot 1 tick", {31'b0, irq}, 32'h1);
        wr(A_STAT, ACK);
    endtask

    task automatic t_stop();
        logic [31:0] d;
        wr(A_CFG, 32'hC000_0003);
        ticks(1);
        wr(A_CFG, 32'h0);
        rd(A_CFG, d);  check("R6 ctrl zero", d, 32'h0);
        rd(A_STAT, d); check("R6 stat zero", d, 32'h0);
        ticks(10);
        check("R6 no irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_notick_restart();
        logic [31:0] d;
        wr(A_CFG, 32'h8000_0009);
        for (int i = 0; i < 5; i++) @(negedge clk);
        rd(A_STAT, d); check("R10 held", d, 32'h0000_0009);
        ticks(2);
        rd(A_STAT, d); check("R10 two ticks", d, 32'h0000_0007);
        wr(A_CFG, 32'h8000_0010);
        rd(A_STAT, d); check("R7 restart", d, 32'h0000_0010);
        wr(A_CFG, 32'h0);
    endtask

    task automatic t_ack_rules();
        logic [31:0] d;
        wr(A_CFG, 32'h8000_0000);
        ticks(1);
        wr(A_STAT, 32'hBFFF_FFFF);
        check("R8 bit30 low no clear", {31'b0, irq}, 32'h1);
        wr(A_STAT, ACK);
        check("R8 ack clears", {31'b0, irq}, 32'h0);
        rd(A_STAT, d); check("R8 stat flag", d, 32'h0);
    endtask

    task automatic t_collide();
        wr(A_CFG, 32'hC000_0000);
        ticks(1);
        step(1'b1, 1'b1, A_STAT, ACK);
        check("R9 set wins", {31'b0, irq}, 32'h1);
        wr(A_STAT, ACK);
        check("R9 lone ack", {31'b0, irq}, 32'h0);
        wr(A_CFG, 32'h0);
    endtask

    task automatic t_write_vs_tick();
        logic [31:0] d;
        wr(A_CFG, 32'hC000_0007);
        ticks(2);
        rd(A_STAT, d); check("R11 pre", d, 32'h0000_0005);
        step(1'b1, 1'b1, A_CFG, 32'hC000_0002);
        rd(A_STAT, d); check("R11 write wins", d, 32'h0000_0002);
        wr(A_CFG, 32'h0);
    endtask

    task automatic t_map();
        logic [31:0] d;
        wr(A_CFG, 32'hFFFF_FFFF);
        rd(A_CFG, d);  check("R13 bit29 ignored", d, 32'hDFFF_FFFF);
        rd(A_STAT, d); check("R13 full count", d, 32'h1FFF_FFFF);
        rd(3'h2, d);   check("R12 unmapped", d, 32'h0);
        #1 check("R12 no select", bus_rdata, 32'h0);
        ticks(1);
        rd(A_STAT, d); check("R12 stat layout", d, 32'h1FFF_FFFE);
        wr(A_CFG, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_oneshot();
        t_periodic();
        t_minimum();
        t_stop();
        t_notick_restart();
        t_ack_rules();
        t_collide();
        t_write_vs_tick();
        t_map();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule